// File: doc/BRIEF.md
# Pipeline Control Sequencer

This block is the control state machine of a small in-order processor core. It decides, one cycle at a time, what the front end and the decode/execute stage should do: leave reset and load the boot address, wait for the first instruction, run normal decode, flush the pipeline after an instruction that redirects control, take an interrupt, enter debug mode from either the fetch side or the decode side, and park the core in a low-power sleep until something wakes it. The decode stage feeds it instruction flags and stall status. The sequencer drives program-counter redirect requests with a target select, a fetch halt, two flush strobes and the save/restore strobes that the CSR file needs to record or unwind a trap.

When several events arrive in the same cycle, a debug request wins. A trigger hit on the instruction in decode comes next, then a control-changing instruction such as an exception, ECALL, EBREAK, MRET, DRET or WFI, then a single-step stop. A non-maskable interrupt and a maskable interrupt come last, in that order. The sequencer takes no event while a memory request is still outstanding or while the decoded instruction is stalled mid-execution, so that traps stay precise.

Top module: `pipe_ctrl_fsm`

## Requirements
- R1: While `rst_ni` is low the state code is 0 (reset) with only `halt_if_o` high. After release the state steps through 1 (boot) and then 2 (first fetch) on consecutive cycles. In the boot state `pc_set_o` is high with select 0 (boot address).
- R2: In first fetch (state 2) the sequencer waits until `instr_valid_i` is high, then moves to decode (state 3). A valid ordinary instruction keeps it in decode.
- R3: In decode, `mem_busy_i`, or `instr_valid_i` together with `instr_stall_i`, holds the state at 3. No debug, interrupt or flush event is taken during the hold.
- R4: Outside debug mode, with no hold, `dbg_req_i` in first fetch or decode moves to fetch-side debug entry (state 5), even when an exception or interrupt arrives in the same cycle. State 5 drives `pc_set_o` with select 6 (debug vector), `dbg_save_o`, `flush_if_o` and `flush_id_o`. It then returns to decode with `debug_mode_o` high.
- R5: A valid instruction with `exc_i`, `ecall_i`, or `ebreak_i` (without `ebreak_to_dbg_i`) moves to flush (state 7) for one cycle, even when an NMI is raised at the same time. The flush drives `pc_set_o` with select 1 (trap vector), `csr_save_o` and both flush strobes, and the sequencer then returns to decode.
- R6: A valid MRET gives a flush with select 4 (saved trap PC) and `csr_mret_o`. A valid DRET gives a flush with select 5 (saved debug PC) and `csr_dret_o`, and clears `debug_mode_o` from the next cycle.
- R7: A trigger match on a valid instruction outside debug mode, or a valid EBREAK with `ebreak_to_dbg_i`, gives a flush with only the two flush strobes. Decode-side debug entry (state 6) follows, with the same outputs as state 5 plus `dpc_from_id_o`.
- R8: An NMI is taken whether or not interrupts are enabled, and it beats a maskable interrupt. A maskable interrupt needs `irq_enable_i`. The interrupt state (4) drives `pc_set_o` with select 3 for an NMI or 2 otherwise, plus `csr_save_o` and both flush strobes, and then returns to decode.
- R9: In debug mode, interrupts, the NMI, `dbg_req_i`, `trig_match_i` and `dbg_step_i` have no effect, and decode continues.
- R10: A valid WFI outside debug mode passes through flush, wait-sleep (state 8, `halt_if_o`) and sleep (state 9, `halt_if_o` and `sleeping_o`). In debug mode a WFI flushes and returns to decode.
- R11: Sleep is held, even when a valid instruction is presented, until `irq_pending_i` (enabled or not), `nmi_i` or `dbg_req_i` is high. The sequencer then moves to first fetch.
- R12: With `dbg_step_i` high outside debug mode, a valid ordinary instruction in decode leads to state 5. A control-changing instruction first completes its flush, and the flush is followed by state 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| instr_valid_i | input | 1 | An instruction occupies decode/execute |
| instr_stall_i | input | 1 | That instruction is stalled (multi-cycle or load hazard) |
| mem_busy_i | input | 1 | An earlier memory request is still outstanding |
| exc_i | input | 1 | The decoded instruction raised an exception |
| ecall_i | input | 1 | Decoded ECALL |
| ebreak_i | input | 1 | Decoded EBREAK |
| ebreak_to_dbg_i | input | 1 | EBREAK at the current privilege enters debug mode |
| mret_i | input | 1 | Decoded MRET |
| dret_i | input | 1 | Decoded DRET |
| wfi_i | input | 1 | Decoded WFI |
| irq_pending_i | input | 1 | A maskable interrupt is pending |
| irq_enable_i | input | 1 | Maskable interrupts are globally enabled |
| nmi_i | input | 1 | Non-maskable interrupt |
| dbg_req_i | input | 1 | External debug request |
| dbg_step_i | input | 1 | Single-step mode is on |
| trig_match_i | input | 1 | Hardware trigger matches the decoded instruction |
| ctrl_state_o | output | 4 | Current state code (0 reset ... 9 sleep) |
| pc_set_o | output | 1 | Redirect the program counter |
| pc_sel_o | output | 3 | Redirect target select |
| halt_if_o | output | 1 | Stop fetching |
| flush_if_o | output | 1 | Discard the fetch stage contents |
| flush_id_o | output | 1 | Discard the decode stage contents |
| csr_save_o | output | 1 | Record trap PC and cause |
| csr_mret_o | output | 1 | Restore state from a trap return |
| csr_dret_o | output | 1 | Restore state from a debug return |
| dbg_save_o | output | 1 | Record the debug PC and cause |
| dpc_from_id_o | output | 1 | Debug PC comes from the decoded instruction |
| debug_mode_o | output | 1 | Core is in debug mode |
| sleeping_o | output | 1 | Core is asleep |

## Verification
The hardest paths to reach from the ports are the two-hop ones: a control-changing instruction under single-step, whose flush must hand over to fetch-side debug entry, and the sleep exits, each of which needs a fresh WFI, wait-sleep and sleep before the wake event. The stimulus replays a WFI before every wake source, and in the flush cycle of an ECALL it holds `dbg_step_i` high. Coincident events are driven in single cycles: debug request with exception and interrupt, exception with NMI, NMI with enabled interrupt. These show the priority order directly in the next state code.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int unsigned StW  = 4;
  localparam int unsigned SelW = 3;

  typedef enum logic [StW-1:0] {
    ST_RESET    = StW'(0),
    ST_BOOT     = StW'(1),
    ST_FIRST    = StW'(2),
    ST_DECODE   = StW'(3),
    ST_IRQ      = StW'(4),
    ST_DBG_IF   = StW'(5),
    ST_DBG_ID   = StW'(6),
    ST_FLUSH    = StW'(7),
    ST_WAIT_SLP = StW'(8),
    ST_SLEEP    = StW'(9)
  } ctl_state_e;

  typedef enum logic [SelW-1:0] {
    PCS_BOOT = SelW'(0),
    PCS_TRAP = SelW'(1),
    PCS_IRQ  = SelW'(2),
    PCS_NMI  = SelW'(3),
    PCS_MEPC = SelW'(4),
    PCS_DEPC = SelW'(5),
    PCS_DBG  = SelW'(6)
  } pc_sel_e;

  typedef enum logic [2:0] {
    FC_NONE,
    FC_EXC,
    FC_MRET,
    FC_DRET,
    FC_WFI,
    FC_TRIG,
    FC_EBRK_DBG
  } flush_cause_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_ADVANCE,
    EV_DBG,
    EV_FLUSH,
    EV_NMI,
    EV_IRQ
  } ctl_event_e;

endpackage

// File: rtl/pseq_event_arb.sv
module pseq_event_arb
  import pseq_pkg::*;
(
  input  logic         in_decode_i,
  input  logic         instr_valid_i,
  input  logic         instr_stall_i,
  input  logic         mem_busy_i,
  input  logic         dbg_mode_i,
  input  logic         dbg_req_i,
  input  logic         dbg_step_i,
  input  logic         trig_match_i,
  input  logic         exc_i,
  input  logic         ecall_i,
  input  logic         ebreak_i,
  input  logic         ebreak_to_dbg_i,
  input  logic         mret_i,
  input  logic         dret_i,
  input  logic         wfi_i,
  input  logic         nmi_i,
  input  logic         irq_pending_i,
  input  logic         irq_enable_i,
  output ctl_event_e   evt_o,
  output flush_cause_e cause_o
);

  logic hold;
  logic dec_instr;

  // An outstanding memory access or a stalled instruction blocks every event.
  assign hold      = mem_busy_i | (instr_valid_i & instr_stall_i);
  assign dec_instr = in_decode_i & instr_valid_i;

  // Flush cause of the decoded instruction; a trigger precedes execution.
  always_comb begin
    cause_o = FC_NONE;
    if (trig_match_i && !dbg_mode_i)          cause_o = FC_TRIG;
    else if (exc_i)                           cause_o = FC_EXC;
    else if (ecall_i)                         cause_o = FC_EXC;
    else if (ebreak_i && ebreak_to_dbg_i)     cause_o = FC_EBRK_DBG;
    else if (ebreak_i)                        cause_o = FC_EXC;
    else if (mret_i)                          cause_o = FC_MRET;
    else if (dret_i)                          cause_o = FC_DRET;
    else if (wfi_i)                           cause_o = FC_WFI;
  end

  // Event priority: debug, flush, step stop, NMI, maskable interrupt.
  always_comb begin
    evt_o = EV_NONE;
    if (hold)                                          evt_o = EV_NONE;
    else if (dbg_req_i && !dbg_mode_i)                 evt_o = EV_DBG;
    else if (dec_instr && cause_o != FC_NONE)          evt_o = EV_FLUSH;
    else if (dec_instr && dbg_step_i && !dbg_mode_i)   evt_o = EV_DBG;
    else if (nmi_i && !dbg_mode_i)                     evt_o = EV_NMI;
    else if (irq_pending_i && irq_enable_i && !dbg_mode_i) evt_o = EV_IRQ;
    else if (instr_valid_i && !in_decode_i)            evt_o = EV_ADVANCE;
  end

endmodule

// File: rtl/pseq_next_state.sv
module pseq_next_state
  import pseq_pkg::*;
(
  input  ctl_state_e   st_i,
  input  ctl_event_e   evt_i,
  input  flush_cause_e cause_q_i,
  input  logic         dbg_mode_i,
  input  logic         dbg_step_i,
  input  logic         wake_i,
  output ctl_state_e   st_o
);

  always_comb begin
    st_o = st_i;
    case (st_i)
      ST_RESET: st_o = ST_BOOT;
      ST_BOOT:  st_o = ST_FIRST;
      ST_FIRST, ST_DECODE: begin
        case (evt_i)
          EV_DBG:     st_o = ST_DBG_IF;
          EV_FLUSH:   st_o = ST_FLUSH;
          EV_NMI,
          EV_IRQ:     st_o = ST_IRQ;
          EV_ADVANCE: st_o = ST_DECODE;
          default:    st_o = st_i;
        endcase
      end
      ST_FLUSH: begin
        case (cause_q_i)
          FC_TRIG,
          FC_EBRK_DBG: st_o = ST_DBG_ID;
          FC_WFI:      st_o = dbg_mode_i ? ST_DECODE : ST_WAIT_SLP;
          default:     st_o = (dbg_step_i && !dbg_mode_i) ? ST_DBG_IF : ST_DECODE;
        endcase
      end
      ST_IRQ, ST_DBG_IF, ST_DBG_ID: st_o = ST_DECODE;
      ST_WAIT_SLP: st_o = ST_SLEEP;
      ST_SLEEP:    st_o = wake_i ? ST_FIRST : ST_SLEEP;
      default:     st_o = ST_RESET;
    endcase
  end

endmodule

// File: rtl/pseq_out_dec.sv
module pseq_out_dec
  import pseq_pkg::*;
(
  input  ctl_state_e      st_i,
  input  flush_cause_e    cause_q_i,
  input  logic            nmi_q_i,
  output logic            pc_set_o,
  output logic [SelW-1:0] pc_sel_o,
  output logic            halt_if_o,
  output logic            flush_if_o,
  output logic            flush_id_o,
  output logic            csr_save_o,
  output logic            csr_mret_o,
  output logic            csr_dret_o,
  output logic            dbg_save_o,
  output logic            dpc_from_id_o,
  output logic            sleeping_o
);

  always_comb begin
    pc_set_o      = 1'b0;
    pc_sel_o      = PCS_BOOT;
    halt_if_o     = 1'b0;
    flush_if_o    = 1'b0;
    flush_id_o    = 1'b0;
    csr_save_o    = 1'b0;
    csr_mret_o    = 1'b0;
    csr_dret_o    = 1'b0;
    dbg_save_o    = 1'b0;
    dpc_from_id_o = 1'b0;
    sleeping_o    = 1'b0;
    case (st_i)
      ST_RESET: halt_if_o = 1'b1;
      ST_BOOT: begin
        pc_set_o = 1'b1;
        pc_sel_o = PCS_BOOT;
      end
      ST_IRQ: begin
        pc_set_o   = 1'b1;
        pc_sel_o   = nmi_q_i ? PCS_NMI : PCS_IRQ;
        flush_if_o = 1'b1;
        flush_id_o = 1'b1;
        csr_save_o = 1'b1;
      end
      ST_DBG_IF, ST_DBG_ID: begin
        pc_set_o      = 1'b1;
        pc_sel_o      = PCS_DBG;
        flush_if_o    = 1'b1;
        flush_id_o    = 1'b1;
        dbg_save_o    = 1'b1;
        dpc_from_id_o = (st_i == ST_DBG_ID);
      end
      ST_FLUSH: begin
        flush_if_o = 1'b1;
        flush_id_o = 1'b1;
        case (cause_q_i)
          FC_EXC: begin
            pc_set_o   = 1'b1;
            pc_sel_o   = PCS_TRAP;
            csr_save_o = 1'b1;
          end
          FC_MRET: begin
            pc_set_o   = 1'b1;
            pc_sel_o   = PCS_MEPC;
            csr_mret_o = 1'b1;
          end
          FC_DRET: begin
            pc_set_o   = 1'b1;
            pc_sel_o   = PCS_DEPC;
            csr_dret_o = 1'b1;
          end
          default: ;
        endcase
      end
      ST_WAIT_SLP: halt_if_o = 1'b1;
      ST_SLEEP: begin
        halt_if_o  = 1'b1;
        sleeping_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pipe_ctrl_fsm.sv
module pipe_ctrl_fsm
  import pseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  input  logic                instr_stall_i,
  input  logic                mem_busy_i,
  input  logic                exc_i,
  input  logic                ecall_i,
  input  logic                ebreak_i,
  input  logic                ebreak_to_dbg_i,
  input  logic                mret_i,
  input  logic                dret_i,
  input  logic                wfi_i,
  input  logic                irq_pending_i,
  input  logic                irq_enable_i,
  input  logic                nmi_i,
  input  logic                dbg_req_i,
  input  logic                dbg_step_i,
  input  logic                trig_match_i,
  output logic [StW-1:0]      ctrl_state_o,
  output logic                pc_set_o,
  output logic [SelW-1:0]     pc_sel_o,
  output logic                halt_if_o,
  output logic                flush_if_o,
  output logic                flush_id_o,
  output logic                csr_save_o,
  output logic                csr_mret_o,
  output logic                csr_dret_o,
  output logic                dbg_save_o,
  output logic                dpc_from_id_o,
  output logic                debug_mode_o,
  output logic                sleeping_o
);

  ctl_state_e   st_q, st_d;
  ctl_event_e   evt;
  flush_cause_e cause, cause_q;
  logic         nmi_q;
  logic         dbg_mode_q, dbg_mode_d;
  logic         in_window, in_decode;
  logic         cause_en, irq_en, wake;

  assign in_decode = (st_q == ST_DECODE);
  assign in_window = in_decode | (st_q == ST_FIRST);
  assign wake      = irq_pending_i | nmi_i | dbg_req_i;

  pseq_event_arb u_arb (
    .in_decode_i     (in_decode),
    .instr_valid_i   (instr_valid_i),
    .instr_stall_i   (instr_stall_i),
    .mem_busy_i      (mem_busy_i),
    .dbg_mode_i      (dbg_mode_q),
    .dbg_req_i       (dbg_req_i),
    .dbg_step_i      (dbg_step_i),
    .trig_match_i    (trig_match_i),
    .exc_i           (exc_i),
    .ecall_i         (ecall_i),
    .ebreak_i        (ebreak_i),
    .ebreak_to_dbg_i (ebreak_to_dbg_i),
    .mret_i          (mret_i),
    .dret_i          (dret_i),
    .wfi_i           (wfi_i),
    .nmi_i           (nmi_i),
    .irq_pending_i   (irq_pending_i),
    .irq_enable_i    (irq_enable_i),
    .evt_o           (evt),
    .cause_o         (cause)
  );

  pseq_next_state u_next (
    .st_i       (st_q),
    .evt_i      (evt),
    .cause_q_i  (cause_q),
    .dbg_mode_i (dbg_mode_q),
    .dbg_step_i (dbg_step_i),
    .wake_i     (wake),
    .st_o       (st_d)
  );

  // Debug mode: entered through either debug entry state, left by a DRET flush.
  always_comb begin
    dbg_mode_d = dbg_mode_q;
    if (st_q == ST_DBG_IF || st_q == ST_DBG_ID)        dbg_mode_d = 1'b1;
    else if (st_q == ST_FLUSH && cause_q == FC_DRET)   dbg_mode_d = 1'b0;
  end

  assign cause_en = in_window & (evt == EV_FLUSH);
  assign irq_en   = in_window & ((evt == EV_NMI) | (evt == EV_IRQ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RESET;
      dbg_mode_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      dbg_mode_q <= dbg_mode_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= FC_NONE;
    end else if (cause_en) begin
      cause_q <= cause;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
    end else if (irq_en) begin
      nmi_q <= (evt == EV_NMI);
    end
  end

  pseq_out_dec u_out (
    .st_i          (st_q),
    .cause_q_i     (cause_q),
    .nmi_q_i       (nmi_q),
    .pc_set_o      (pc_set_o),
    .pc_sel_o      (pc_sel_o),
    .halt_if_o     (halt_if_o),
    .flush_if_o    (flush_if_o),
    .flush_id_o    (flush_id_o),
    .csr_save_o    (csr_save_o),
    .csr_mret_o    (csr_mret_o),
    .csr_dret_o    (csr_dret_o),
    .dbg_save_o    (dbg_save_o),
    .dpc_from_id_o (dpc_from_id_o),
    .sleeping_o    (sleeping_o)
  );

  assign ctrl_state_o = st_q;
  assign debug_mode_o = dbg_mode_q;

  p_boot_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RESET |=> st_q == ST_BOOT);

  p_mem_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECODE && mem_busy_i) |=> st_q == ST_DECODE);

  p_flush_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FLUSH |=> st_q != ST_FLUSH);

  p_flush_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLUSH && pc_set_o) |-> (csr_save_o || csr_mret_o || csr_dret_o));

  p_dbg_mode_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECODE && dbg_mode_q) |=> (st_q != ST_IRQ && st_q != ST_DBG_IF));

  p_wait_to_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT_SLP |=> st_q == ST_SLEEP);

  p_sleep_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && (irq_pending_i || nmi_i || dbg_req_i)) |=> st_q == ST_FIRST);

endmodule

// File: tb/pipe_ctrl_fsm_bench.sv
module pipe_ctrl_fsm_bench;

  // Stimulus bits
  localparam logic [15:0] I_IRQ = 16'h0001, I_IEN = 16'h0002, I_NMI = 16'h0004,
                          I_DBG = 16'h0008, I_STP = 16'h0010, I_TRG = 16'h0020,
                          I_V   = 16'h0040, I_STL = 16'h0080, I_MB  = 16'h0100,
                          I_EXC = 16'h0200, I_ECL = 16'h0400, I_EBK = 16'h0800,
                          I_EBD = 16'h1000, I_MRT = 16'h2000, I_DRT = 16'h4000,
                          I_WFI = 16'h8000;

  // State codes (R1..R10)
  localparam logic [3:0] S_RS = 4'd0, S_BS = 4'd1, S_FF = 4'd2, S_DC = 4'd3,
                         S_IT = 4'd4, S_DI = 4'd5, S_DD = 4'd6, S_FL = 4'd7,
                         S_WS = 4'd8, S_SL = 4'd9;

  // Output vector: pc_set, sel[3], halt, fif, fid, save, mret, dret, dsave, did, dm, slp
  localparam logic [13:0] O_0      = 14'd0;
  localparam logic [13:0] O_HALT   = {1'b0, 3'd0, 1'b1, 9'b0};
  localparam logic [13:0] O_SLP    = {1'b0, 3'd0, 1'b1, 8'b0, 1'b1};
  localparam logic [13:0] O_BOOT   = {1'b1, 3'd0, 10'b0};
  localparam logic [13:0] O_FL     = {1'b0, 3'd0, 1'b0, 2'b11, 7'b0};
  localparam logic [13:0] O_FL_EXC = {1'b1, 3'd1, 1'b0, 2'b11, 1'b1, 6'b0};
  localparam logic [13:0] O_FL_MRT = {1'b1, 3'd4, 1'b0, 2'b11, 1'b0, 1'b1, 5'b0};
  localparam logic [13:0] O_FL_DRT = {1'b1, 3'd5, 1'b0, 2'b11, 2'b0, 1'b1, 2'b0, 1'b1, 1'b0};
  localparam logic [13:0] O_IT_IRQ = {1'b1, 3'd2, 1'b0, 2'b11, 1'b1, 6'b0};
  localparam logic [13:0] O_IT_NMI = {1'b1, 3'd3, 1'b0, 2'b11, 1'b1, 6'b0};
  localparam logic [13:0] O_DI     = {1'b1, 3'd6, 1'b0, 2'b11, 3'b0, 1'b1, 3'b0};
  localparam logic [13:0] O_DD     = {1'b1, 3'd6, 1'b0, 2'b11, 3'b0, 2'b11, 2'b0};
  localparam logic [13:0] O_DM     = 14'h0002;

  logic        clk, rst_n;
  logic [15:0] stim;
  logic [3:0]  st_o;
  logic [2:0]  sel_o;
  logic        pcs, halt, fif, fid, sv, mr, dr, ds, di, dm, slp;
  logic [13:0] obs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  q_st[$];
  logic [13:0] q_o[$];
  string       q_req[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  pipe_ctrl_fsm u_pipe_ctrl_fsm (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .instr_valid_i   (stim[6]),
    .instr_stall_i   (stim[7]),
    .mem_busy_i      (stim[8]),
    .exc_i           (stim[9]),
    .ecall_i         (stim[10]),
    .ebreak_i        (stim[11]),
    .ebreak_to_dbg_i (stim[12]),
    .mret_i          (stim[13]),
    .dret_i          (stim[14]),
    .wfi_i           (stim[15]),
    .irq_pending_i   (stim[0]),
    .irq_enable_i    (stim[1]),
    .nmi_i           (stim[2]),
    .dbg_req_i       (stim[3]),
    .dbg_step_i      (stim[4]),
    .trig_match_i    (stim[5]),
    .ctrl_state_o    (st_o),
    .pc_set_o        (pcs),
    .pc_sel_o        (sel_o),
    .halt_if_o       (halt),
    .flush_if_o      (fif),
    .flush_id_o      (fid),
    .csr_save_o      (sv),
    .csr_mret_o      (mr),
    .csr_dret_o      (dr),
    .dbg_save_o      (ds),
    .dpc_from_id_o   (di),
    .debug_mode_o    (dm),
    .sleeping_o      (slp)
  );

  assign obs = {pcs, sel_o, halt, fif, fid, sv, mr, dr, ds, di, dm, slp};

  // Driver: one cycle of stimulus, expectation for the state after the next edge
  task automatic cyc(input logic [15:0] s, input logic [3:0] est,
                     input logic [13:0] eo, input string req);
    @(negedge clk);
    stim = s;
    q_st.push_back(est);
    q_o.push_back(eo);
    q_req.push_back(req);
  endtask

  task automatic leave_dbg();
    cyc(I_V | I_DRT, S_FL, O_FL_DRT | O_DM, "R6");
    cyc(16'h0,       S_DC, O_0,            "R6");
  endtask

  task automatic go_sleep();
    cyc(I_V | I_WFI, S_FL, O_FL,   "R10");
    cyc(16'h0,       S_WS, O_HALT, "R10");
    cyc(16'h0,       S_SL, O_SLP,  "R10");
  endtask

  // Monitor: compares two time units after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_st.size() > 0) begin
      logic [3:0]  est;
      logic [13:0] eo;
      string       rq;
      est = q_st.pop_front();
      eo  = q_o.pop_front();
      rq  = q_req.pop_front();
      checks++;
      if (st_o !== est || obs !== eo) begin
        fails++;
        $display("FAIL %s: state %0d outs %b, expected state %0d outs %b",
                 rq, st_o, obs, est, eo);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    stim  = 16'h0;
    // R1 reset state
    cyc(16'h0, S_RS, O_HALT, "R1");
    cyc(I_V | I_DBG, S_RS, O_HALT, "R1");
    cyc(16'h0, S_RS, O_HALT, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    stim  = 16'h0;
    q_st.push_back(S_BS); q_o.push_back(O_BOOT); q_req.push_back("R1");
    cyc(16'h0, S_FF, O_0, "R1");
    // R2 first fetch waits
    cyc(16'h0, S_FF, O_0, "R2");
    cyc(I_V,   S_DC, O_0, "R2");
    cyc(I_V,   S_DC, O_0, "R2");
    // R3 holds
    cyc(I_V | I_STL | I_IRQ | I_IEN, S_DC, O_0, "R3");
    cyc(I_MB | I_NMI, S_DC, O_0, "R3");
    cyc(I_MB | I_DBG | I_V | I_EXC, S_DC, O_0, "R3");
    // R8 interrupts
    cyc(I_V | I_NMI | I_IRQ | I_IEN, S_IT, O_IT_NMI, "R8");
    cyc(16'h0, S_DC, O_0, "R8");
    cyc(I_V | I_IRQ, S_DC, O_0, "R8");
    cyc(I_V | I_IRQ | I_IEN, S_IT, O_IT_IRQ, "R8");
    cyc(16'h0, S_DC, O_0, "R8");
    // R5 exceptions
    cyc(I_V | I_EXC | I_NMI, S_FL, O_FL_EXC, "R5");
    cyc(16'h0, S_DC, O_0, "R5");
    cyc(I_V | I_ECL, S_FL, O_FL_EXC, "R5");
    cyc(16'h0, S_DC, O_0, "R5");
    cyc(I_V | I_EBK, S_FL, O_FL_EXC, "R5");
    cyc(16'h0, S_DC, O_0, "R5");
    // R6 trap return
    cyc(I_V | I_MRT, S_FL, O_FL_MRT, "R6");
    cyc(16'h0, S_DC, O_0, "R6");
    // R4 debug request beats exception and interrupt
    cyc(I_V | I_EXC | I_DBG | I_IRQ | I_IEN, S_DI, O_DI, "R4");
    cyc(16'h0, S_DC, O_DM, "R4");
    // R9 events ignored in debug mode
    cyc(I_V | I_IRQ | I_IEN | I_NMI | I_DBG | I_TRG | I_STP, S_DC, O_DM, "R9");
    // R10 wfi inside debug mode
    cyc(I_V | I_WFI, S_FL, O_FL | O_DM, "R10");
    cyc(16'h0, S_DC, O_DM, "R10");
    leave_dbg();
    // R7 trigger and ebreak to debug
    cyc(I_V | I_TRG, S_FL, O_FL, "R7");
    cyc(16'h0, S_DD, O_DD, "R7");
    cyc(16'h0, S_DC, O_DM, "R7");
    leave_dbg();
    cyc(I_V | I_EBK | I_EBD, S_FL, O_FL, "R7");
    cyc(16'h0, S_DD, O_DD, "R7");
    cyc(16'h0, S_DC, O_DM, "R7");
    leave_dbg();
    // R12 single step
    cyc(I_V | I_STP, S_DI, O_DI, "R12");
    cyc(16'h0, S_DC, O_DM, "R12");
    leave_dbg();
    cyc(I_V | I_ECL | I_STP, S_FL, O_FL_EXC, "R12");
    cyc(I_STP, S_DI, O_DI, "R12");
    cyc(16'h0, S_DC, O_DM, "R12");
    leave_dbg();
    // R10/R11 sleep and wake sources
    go_sleep();
    cyc(16'h0, S_SL, O_SLP, "R11");
    cyc(I_V,   S_SL, O_SLP, "R11");
    cyc(I_IRQ, S_FF, O_0,   "R11");
    cyc(I_V,   S_DC, O_0,   "R2");
    go_sleep();
    cyc(I_DBG, S_FF, O_0,  "R11");
    cyc(I_DBG, S_DI, O_DI, "R4");
    cyc(16'h0, S_DC, O_DM, "R4");
    leave_dbg();
    go_sleep();
    cyc(I_NMI, S_FF, O_0,      "R11");
    cyc(I_NMI, S_IT, O_IT_NMI, "R8");
    cyc(16'h0, S_DC, O_0,      "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule